// File: doc/BRIEF.md
# Saturating Add/Subtract Unit With Doubling

This block computes a signed 32-bit sum or difference that clamps at the ends of the signed range instead of wrapping. Before the add or subtract, the second operand can be doubled. The doubling has its own clamp. When either the doubling or the final operation goes out of range, the block raises a one-cycle saturation pulse and sets a sticky saturation flag that it keeps internally. Only an external clear input brings that flag back to zero.

An issuing pipeline presents the operands and two control bits together with a valid strobe. The result is registered and appears one cycle later. An architecture enable input gates the operation. If that enable is low, the block raises a one-cycle undefined-instruction trap in place of a result. During a trap it leaves the result register and the flag untouched.

The control is a three-state machine:
- `ST_IDLE`: nothing was issued.
- `ST_RESULT`: a computed result is presented.
- `ST_TRAP`: a trap is presented.

From any state, the transitions are:
- to `ST_RESULT` on `op_valid && ext_enable`;
- to `ST_TRAP` on `op_valid && !ext_enable`;
- to `ST_IDLE` otherwise.

Top module: `qsat_unit`

## Requirements
- R1: After an edge that samples `op_valid` high with `ext_enable` high, `res_valid` is high for exactly the following cycle, and `res_data` holds that operation's result. With no such edge, `res_valid` is low.
- R2: With `op_sub` = 0 the result is first + second'. With `op_sub` = 1 it is first − second'. Here second' is the possibly doubled second operand, and values are two's complement.
- R3: With `op_dbl` = 1, second' is twice `op_b`. If that doubling leaves the signed 32-bit range, second' becomes 0x7FFFFFFF for a non-negative `op_b` or 0x80000000 for a negative `op_b`, and the operation counts as saturated.
- R4: If the exact add or subtract leaves the signed 32-bit range, the result is 0x7FFFFFFF when the exact value is positive and 0x80000000 when it is negative. The exact value is the 33-bit intermediate.
- R5: `sat_pulse` is high in the result cycle exactly when the doubling or the final operation saturated. `sat_flag` is high in that same cycle.
- R6: `sat_flag` never falls except at an edge where `flag_clear` is high. If a saturation occurs at the same edge as a clear, the flag still ends up set.
- R7: An operation issued with `ext_enable` low produces `res_trap` high for one cycle. In that cycle `res_valid` and `sat_pulse` are low, and `res_data` and `sat_flag` keep their previous values.
- R8: While reset is active, `res_valid`, `res_trap`, `sat_pulse` and `sat_flag` are 0 and `res_data` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation issue strobe |
| op_a | input | 32 | First operand (signed) |
| op_b | input | 32 | Second operand (signed) |
| op_sub | input | 1 | 1 = subtract, 0 = add |
| op_dbl | input | 1 | 1 = double the second operand first |
| ext_enable | input | 1 | Architecture enable; low turns an issue into a trap |
| flag_clear | input | 1 | External clear of the sticky flag |
| res_valid | output | 1 | Result presented this cycle |
| res_data | output | 32 | Saturated result |
| res_trap | output | 1 | Undefined-instruction trap this cycle |
| sat_pulse | output | 1 | Saturation occurred in the presented result |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every output is due one cycle after the edge that samples the issue or the clear: `res_valid`, `res_data`, `res_trap`, `sat_pulse` and `sat_flag` all change at that edge. The bench therefore drives inputs on the falling edge and checks 1 ns after the next rising edge. It looks again one cycle later to confirm that the pulses have dropped. Expected sums and flags come from a 64-bit reference with explicit clamping and a bench-side model of the sticky flag.

// File: rtl/qsat_pkg.sv
package qsat_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_TRAP   = 2'd2
    } qsat_state_e;
endpackage

// File: rtl/qsat_double.sv
module qsat_double #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] din,
    input  logic          en,
    output logic [DW-1:0] dout,
    output logic          sat
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic ovf;

    always_comb begin
        // shifting left loses the sign when the top two bits differ
        ovf = en && (din[DW-1] != din[DW-2]);
        if (!en)
            dout = din;
        else if (ovf)
            dout = din[DW-1] ? SMIN : SMAX;
        else
            dout = {din[DW-2:0], 1'b0};
        sat = ovf;
    end
endmodule

// File: rtl/qsat_addsub.sv
module qsat_addsub #(
    parameter int DW = 32
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          sub,
    output logic [DW-1:0] res,
    output logic          sat
);
    localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW:0] wide;

    always_comb begin
        // one guard bit keeps the exact sign of the result
        if (sub)
            wide = {a[DW-1], a} - {b[DW-1], b};
        else
            wide = {a[DW-1], a} + {b[DW-1], b};
        sat = wide[DW] != wide[DW-1];
        if (sat)
            res = wide[DW] ? SMIN : SMAX;
        else
            res = wide[DW-1:0];
    end
endmodule

// File: rtl/qsat_unit.sv
module qsat_unit #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic          op_sub,
    input  logic          op_dbl,
    input  logic          ext_enable,
    input  logic          flag_clear,
    output logic          res_valid,
    output logic [DW-1:0] res_data,
    output logic          res_trap,
    output logic          sat_pulse,
    output logic          sat_flag
);
    import qsat_pkg::*;

    qsat_state_e   state_q, state_d;
    logic [DW-1:0] b_eff, sum;
    logic          dbl_sat, fin_sat, go, any_sat;
    logic          pulse_q, flag_q;
    logic [DW-1:0] data_q;

    qsat_double #(.DW(DW)) u_double (
        .din  (op_b),
        .en   (op_dbl),
        .dout (b_eff),
        .sat  (dbl_sat)
    );

    qsat_addsub #(.DW(DW)) u_addsub (
        .a   (op_a),
        .b   (b_eff),
        .sub (op_sub),
        .res (sum),
        .sat (fin_sat)
    );

    assign go      = op_valid && ext_enable;
    assign any_sat = dbl_sat || fin_sat;

    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_TRAP: begin
                if (go)
                    state_d = ST_RESULT;
                else if (op_valid)
                    state_d = ST_TRAP;
                else
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= go && any_sat;
            if (go)
                data_q <= sum;
            // a new saturation outranks a clear at the same edge
            flag_q <= (flag_q && !flag_clear) || (go && any_sat);
        end
    end

    always_comb begin
        res_valid = 1'b0;
        res_trap  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: res_valid = 1'b1;
            ST_TRAP:   res_trap  = 1'b1;
            default:   ;
        endcase
        res_data  = data_q;
        sat_pulse = pulse_q;
        sat_flag  = flag_q;
    end

    AST_ISSUE_TO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> res_valid && !res_trap); // R1
    AST_PULSE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        sat_pulse |-> sat_flag && res_valid); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        sat_flag && !flag_clear |=> sat_flag); // R6
    AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid && !ext_enable |=> res_trap && !res_valid && !sat_pulse && $stable(res_data) && $stable(sat_flag)); // R7
    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !go |=> $stable(res_data)); // R7
endmodule

// File: tb/qsat_unit_bench.sv
`timescale 1ns/1ps
module qsat_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        op_sub = 1'b0;
    logic        op_dbl = 1'b0;
    logic        ext_enable = 1'b1;
    logic        flag_clear = 1'b0;
    logic        res_valid, res_trap, sat_pulse, sat_flag;
    logic [31:0] res_data;

    int checks = 0;
    int errors = 0;
    logic model_flag = 1'b0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    qsat_unit u_qsat_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_a(op_a), .op_b(op_b),
        .op_sub(op_sub), .op_dbl(op_dbl), .ext_enable(ext_enable), .flag_clear(flag_clear),
        .res_valid(res_valid), .res_data(res_data), .res_trap(res_trap),
        .sat_pulse(sat_pulse), .sat_flag(sat_flag)
    );

    // fields: {sub, dbl, a, b}
    localparam int NV = 12;
    localparam logic [65:0] VECS [NV] = '{
        {1'b0, 1'b0, 32'h0000_0005, 32'h0000_0007},
        {1'b1, 1'b0, 32'h0000_0005, 32'h0000_0007},
        {1'b0, 1'b0, 32'h7FFF_FFFF, 32'h0000_0001},
        {1'b1, 1'b0, 32'h8000_0000, 32'h0000_0001},
        {1'b1, 1'b0, 32'h0000_0000, 32'h8000_0000},
        {1'b0, 1'b1, 32'h0000_000A, 32'h0000_0014},
        {1'b1, 1'b1, 32'h0000_0064, 32'h0000_001E},
        {1'b0, 1'b1, 32'h0000_0000, 32'h4000_0000},
        {1'b0, 1'b1, 32'hFFFF_FFFF, 32'hC000_0000},
        {1'b1, 1'b1, 32'h0000_0000, 32'hC000_0000},
        {1'b1, 1'b1, 32'hFFFF_FFFB, 32'hBFFF_FFFF},
        {1'b0, 1'b0, 32'h8000_0000, 32'h8000_0000}
    };

    function automatic logic [32:0] ref_op(logic sub, logic dbl, logic [31:0] a, logic [31:0] b);
        longint sa, sb, r;
        logic s;
        s  = 1'b0;
        sa = longint'($signed(a));
        sb = longint'($signed(b));
        if (dbl) begin
            sb = sb * 2;
            if (sb > 64'sd2147483647) begin sb = 64'sd2147483647; s = 1'b1; end
            else if (sb < -64'sd2147483648) begin sb = -64'sd2147483648; s = 1'b1; end
        end
        r = sub ? sa - sb : sa + sb;
        if (r > 64'sd2147483647) begin r = 64'sd2147483647; s = 1'b1; end
        else if (r < -64'sd2147483648) begin r = -64'sd2147483648; s = 1'b1; end
        return {s, r[31:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic sub, logic dbl, logic [31:0] a, logic [31:0] b, logic en, logic clr);
        @(negedge clk);
        op_valid = 1'b1; op_sub = sub; op_dbl = dbl; op_a = a; op_b = b;
        ext_enable = en; flag_clear = clr;
        @(posedge clk);
        #1;
        @(negedge clk);
        op_valid = 1'b0; flag_clear = 1'b0; ext_enable = 1'b1;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [32:0] exp;
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1;
        check("R8 res_valid", 32'(res_valid), 32'd0);
        check("R8 res_trap",  32'(res_trap),  32'd0);
        check("R8 sat_pulse", 32'(sat_pulse), 32'd0);
        check("R8 sat_flag",  32'(sat_flag),  32'd0);
        check("R8 res_data",  res_data,       32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            exp = ref_op(VECS[i][65], VECS[i][64], VECS[i][63:32], VECS[i][31:0]);
            @(negedge clk);
            op_valid = 1'b1; op_sub = VECS[i][65]; op_dbl = VECS[i][64];
            op_a = VECS[i][63:32]; op_b = VECS[i][31:0]; ext_enable = 1'b1;
            @(posedge clk);
            #1;
            model_flag = model_flag | exp[32];
            check("R1 res_valid", 32'(res_valid), 32'd1);
            check("R2 R3 R4 res_data", res_data, exp[31:0]);
            check("R5 sat_pulse", 32'(sat_pulse), 32'(exp[32]));
            check("R6 sat_flag", 32'(sat_flag), 32'(model_flag));
            @(negedge clk);
            op_valid = 1'b0;
            @(posedge clk);
            #1;
            check("R1 res_valid drops", 32'(res_valid), 32'd0);
            check("R5 sat_pulse drops", 32'(sat_pulse), 32'd0);
            check("R6 sat_flag holds", 32'(sat_flag), 32'(model_flag));
        end

        // clear the flag
        @(negedge clk); flag_clear = 1'b1;
        @(posedge clk); #1;
        check("R6 clear", 32'(sat_flag), 32'd0);
        @(negedge clk); flag_clear = 1'b0;

        // saturating op together with clear: set wins
        @(negedge clk);
        op_valid = 1'b1; op_sub = 1'b0; op_dbl = 1'b0;
        op_a = 32'h7FFF_FFF0; op_b = 32'h0000_0100; flag_clear = 1'b1;
        @(posedge clk); #1;
        check("R6 set beats clear", 32'(sat_flag), 32'd1);
        check("R4 clamp max", res_data, 32'h7FFF_FFFF);
        @(negedge clk); op_valid = 1'b0; flag_clear = 1'b0;
        @(negedge clk); flag_clear = 1'b1;
        @(negedge clk); flag_clear = 1'b0;

        // non-saturating op leaves cleared flag low
        @(negedge clk);
        op_valid = 1'b1; op_sub = 1'b1; op_dbl = 1'b1;
        op_a = 32'h0000_1000; op_b = 32'h0000_0010;
        @(posedge clk); #1;
        check("R3 small double", res_data, 32'h0000_0FE0);
        check("R5 no pulse", 32'(sat_pulse), 32'd0);
        check("R6 flag stays clear", 32'(sat_flag), 32'd0);
        held = res_data;
        @(negedge clk); op_valid = 1'b0;

        // trap with saturating operands
        @(negedge clk);
        op_valid = 1'b1; op_sub = 1'b0; op_dbl = 1'b1;
        op_a = 32'h7FFF_FFFF; op_b = 32'h4000_0000; ext_enable = 1'b0;
        @(posedge clk); #1;
        check("R7 res_trap", 32'(res_trap), 32'd1);
        check("R7 res_valid low", 32'(res_valid), 32'd0);
        check("R7 no pulse", 32'(sat_pulse), 32'd0);
        check("R7 data held", res_data, held);
        check("R7 flag unchanged", 32'(sat_flag), 32'd0);
        @(negedge clk); op_valid = 1'b0; ext_enable = 1'b1;
        @(posedge clk); #1;
        check("R7 trap one cycle", 32'(res_trap), 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule